// File: doc/BRIEF.md
# Dual PCM Codec Serial Port

This block moves 8-bit companded (mu-law) samples between a parallel core and two telephone codecs over serial links. It divides the system clock by twelve, so a 24.576 MHz system clock gives a 2.048 MHz bit clock. It also generates a frame sync once every 256 bit periods, which gives an 8 kHz frame. Both codecs share the bit clock and the frame sync. Each codec has its own transmit line and its own receive line.

In every frame, each active codec is sent one byte, most significant bit first, in the eight bit periods that follow the sync period. One byte is captured from each active codec in the same eight periods. The receive bytes appear on parallel registers at a one-cycle frame strobe, and the next transmit bytes are taken from the parallel inputs at that same strobe. A per-codec enable sets an inactive flag. While the flag is set, the codec's transmit line is held high and its receive register is frozen, so an unused codec can be powered down.

Top module: `pcm_dual_port`

## Requirements
- R1: While reset is asserted, the outputs are as follows: bit clock high, frame sync high, every transmit line high, every receive register 0x00, frame strobe low, every inactive flag high.
- R2: The bit clock period is 12 system cycles. It is high for the first 6 cycles and low for the last 6. A bit period begins in the first cycle after reset.
- R3: Bit periods are numbered 0 to 255 within a frame. Frame sync is high during all of period 0 and low otherwise, so it rises together with the bit clock.
- R4: In periods 1 to 8, an active codec's transmit line carries bit 8-p of its held transmit byte during period p, so the MSB goes out first. In all other periods the line is high.
- R5: The receive line is sampled at the falling bit-clock edge of periods 1 to 8, and the first sample becomes the MSB of the received byte.
- R6: The frame strobe is high for exactly one system cycle, the first cycle of period 9. At that edge each active codec's receive register takes the byte captured in periods 1 to 8.
- R7: Each codec's transmit byte is sampled at the edge that raises the frame strobe. It is sent in the following frame. After reset the held byte is 0xFF.
- R8: The inactive flag equals the inverse of the codec's enable, delayed by one system cycle. While the flag is set, the codec's transmit line stays high in every period.
- R9: While a codec's inactive flag is set, its receive register does not change. The transmit byte is still sampled at each strobe.
- R10: The two codecs are independent. Disabling one changes nothing on the other's lines or registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_data_i | input | 2x8 | Transmit byte per codec |
| en_i | input | 2 | Codec enable, 1 = in use |
| dr_i | input | 2 | Serial receive line per codec |
| bclk_o | output | 1 | Shared bit clock |
| fsync_o | output | 1 | Shared frame sync |
| dx_o | output | 2 | Serial transmit line per codec |
| rx_data_o | output | 2x8 | Receive byte per codec |
| frame_o | output | 1 | One-cycle frame strobe |
| inactive_o | output | 2 | Codec inactive flag |

## Verification
An error in the divider or the period counter shows up within one bit period as a wrong bit-clock level. If the error is in the period count, the frame sync is also wrong within one frame. A wrong period count or a bad shift register shows up in the same frame as a transmit bit in the wrong period, and at the next strobe as a wrong receive byte. A wrong inactive state shows within one cycle on the flag. It also shows within one frame as a driven transmit bit or an updated receive register that should have stayed frozen.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  localparam int unsigned SAMPLE_W = 8;
  typedef logic [SAMPLE_W-1:0] sample_t;
endpackage

// File: rtl/pcm_clkgen.sv
module pcm_clkgen #(
  parameter int unsigned CLK_DIV   = 12,
  parameter int unsigned SLOTS     = 256,
  parameter int unsigned DATA_BITS = 8,
  localparam int unsigned DIV_W    = $clog2(CLK_DIV),
  localparam int unsigned SLOT_W   = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              bclk_o,
  output logic              fsync_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              data_slot_o,
  output logic              smp_stb_o,
  output logic              latch_o,
  output logic              frame_o
);
  localparam int unsigned HALF = CLK_DIV / 2;
  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(CLK_DIV - 1);
  localparam logic [DIV_W-1:0]  DIV_SMP   = DIV_W'(HALF - 1);
  localparam logic [DIV_W-1:0]  DIV_HALF  = DIV_W'(HALF);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);
  localparam logic [SLOT_W-1:0] SLOT_END  = SLOT_W'(DATA_BITS);

  logic [DIV_W-1:0]  div_q;
  logic [SLOT_W-1:0] slot_q;
  logic              frame_q;
  logic              div_wrap;

  assign div_wrap = (div_q == DIV_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      slot_q <= '0;
    end else if (div_wrap) begin
      div_q  <= '0;
      slot_q <= (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign data_slot_o = (slot_q != '0) && (slot_q <= SLOT_END);
  // capture edge coincides with the falling bit-clock edge
  assign smp_stb_o   = data_slot_o && (div_q == DIV_SMP);
  assign latch_o     = div_wrap && (slot_q == SLOT_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frame_q <= 1'b0;
    else         frame_q <= latch_o;
  end

  assign bclk_o  = (div_q < DIV_HALF);
  assign fsync_o = (slot_q == '0);
  assign slot_o  = slot_q;
  assign frame_o = frame_q;

  assert_frame_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_q |=> !frame_q);
  assert_sync_on_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fsync_o) |-> $rose(bclk_o));
  assert_bclk_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bclk_o) |=> $stable(bclk_o));
endmodule

// File: rtl/pcm_lane.sv
module pcm_lane
  import pcm_pkg::*;
#(
  parameter int unsigned SLOT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              dr_i,
  input  sample_t           tx_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              data_slot_i,
  input  logic              smp_stb_i,
  input  logic              latch_i,
  output logic              dx_o,
  output sample_t           rx_o,
  output logic              inactive_o
);
  sample_t tx_hold_q, rx_sh_q, rx_q, tx_sel;
  logic    inact_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inact_q <= 1'b1;
    else         inact_q <= ~en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tx_hold_q <= '1;
    else if (latch_i) tx_hold_q <= tx_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rx_sh_q <= '0;
    else if (smp_stb_i) rx_sh_q <= {rx_sh_q[SAMPLE_W-2:0], dr_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  rx_q <= '0;
    else if (latch_i && !inact_q) rx_q <= rx_sh_q;
  end

  // period p carries bit 8-p
  assign tx_sel     = tx_hold_q << (slot_i - 1'b1);
  assign dx_o       = (inact_q || !data_slot_i) ? 1'b1 : tx_sel[SAMPLE_W-1];
  assign rx_o       = rx_q;
  assign inactive_o = inact_q;

  assert_rx_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inact_q |=> $stable(rx_q));
  assert_flag_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> inactive_o);
endmodule

// File: rtl/pcm_dual_port.sv
module pcm_dual_port
  import pcm_pkg::*;
#(
  parameter int unsigned N_CODEC = 2,
  parameter int unsigned CLK_DIV = 12,
  parameter int unsigned SLOTS   = 256
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [N_CODEC-1:0][SAMPLE_W-1:0]  tx_data_i,
  input  logic [N_CODEC-1:0]                en_i,
  input  logic [N_CODEC-1:0]                dr_i,
  output logic                              bclk_o,
  output logic                              fsync_o,
  output logic [N_CODEC-1:0]                dx_o,
  output logic [N_CODEC-1:0][SAMPLE_W-1:0]  rx_data_o,
  output logic                              frame_o,
  output logic [N_CODEC-1:0]                inactive_o
);
  localparam int unsigned SLOT_W = $clog2(SLOTS);

  logic [SLOT_W-1:0] slot;
  logic              data_slot, smp_stb, latch;

  pcm_clkgen #(
    .CLK_DIV  (CLK_DIV),
    .SLOTS    (SLOTS),
    .DATA_BITS(SAMPLE_W)
  ) u_clkgen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bclk_o     (bclk_o),
    .fsync_o    (fsync_o),
    .slot_o     (slot),
    .data_slot_o(data_slot),
    .smp_stb_o  (smp_stb),
    .latch_o    (latch),
    .frame_o    (frame_o)
  );

  for (genvar c = 0; c < N_CODEC; c++) begin : g_lane
    pcm_lane #(.SLOT_W(SLOT_W)) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (en_i[c]),
      .dr_i       (dr_i[c]),
      .tx_i       (tx_data_i[c]),
      .slot_i     (slot),
      .data_slot_i(data_slot),
      .smp_stb_i  (smp_stb),
      .latch_i    (latch),
      .dx_o       (dx_o[c]),
      .rx_o       (rx_data_o[c]),
      .inactive_o (inactive_o[c])
    );
  end

  assert_sync_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_o |-> &dx_o);
  assert_strobe_off_sync_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> !fsync_o);
endmodule

// File: tb/pcm_dual_port_test.sv
module pcm_dual_port_test;
  localparam int NC     = 2;
  localparam int DIV    = 12;
  localparam int SLOTS  = 256;
  localparam int FRAME  = DIV * SLOTS;
  localparam int NFRM   = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NC-1:0][7:0] tx_data_i;
  logic [NC-1:0]      en_i;
  logic [NC-1:0]      dr_i;
  logic bclk_o, fsync_o, frame_o;
  logic [NC-1:0]      dx_o, inactive_o;
  logic [NC-1:0][7:0] rx_data_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  pcm_dual_port #(.N_CODEC(NC), .CLK_DIV(DIV), .SLOTS(SLOTS)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tx_data_i(tx_data_i), .en_i(en_i),
    .dr_i(dr_i), .bclk_o(bclk_o), .fsync_o(fsync_o), .dx_o(dx_o),
    .rx_data_o(rx_data_o), .frame_o(frame_o), .inactive_o(inactive_o));

  always #5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      if (mismatched < 20)
        $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  function automatic logic [7:0] rxpat(int f, int c);
    return 8'((f * 53 + c * 110 + 7) % 256);
  endfunction
  function automatic logic [7:0] txpat(int f, int c);
    if (f == 2) return (c == 0) ? 8'h00 : 8'h80;
    return 8'((f * 29 + c * 77 + 200) % 256);
  endfunction

  logic [NC-1:0][7:0] exp_hold, exp_rx;
  logic [NC-1:0]      exp_inact;

  initial begin
    for (int c = 0; c < NC; c++) begin
      tx_data_i[c] = txpat(1, c);
      exp_hold[c]  = 8'hFF;
      exp_rx[c]    = 8'h00;
    end
    en_i = '1;
    dr_i = '1;
    exp_inact = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 bclk", bclk_o, 1);
    chk("R1 fsync", fsync_o, 1);
    chk("R1 frame", frame_o, 0);
    for (int c = 0; c < NC; c++) begin
      chk("R1 dx", dx_o[c], 1);
      chk("R1 rx", rx_data_o[c], 0);
      chk("R1 inactive", inactive_o[c], 1);
    end
    rst_ni = 1'b1;
    exp_inact = ~en_i;
    for (int k = 1; k <= NFRM * FRAME; k++) begin
      @(negedge clk);
      begin
        int dv, sl, fr;
        dv = k % DIV;
        sl = (k / DIV) % SLOTS;
        fr = k / FRAME;
        chk("R2 bclk", bclk_o, (dv < DIV / 2) ? 1 : 0);
        chk("R3 fsync", fsync_o, (sl == 0) ? 1 : 0);
        chk("R6 strobe", frame_o, (sl == 9 && dv == 0) ? 1 : 0);
        for (int c = 0; c < NC; c++) begin
          int ex;
          ex = (!exp_inact[c] && sl >= 1 && sl <= 8) ? int'(exp_hold[c][8 - sl]) : 1;
          chk(exp_inact[c] ? "R8 dx idle" : "R4 R7 R10 dx", dx_o[c], ex);
          chk(exp_inact[c] ? "R9 rx hold" : "R5 R6 R10 rx", rx_data_o[c], exp_rx[c]);
          chk("R8 flag", inactive_o[c], exp_inact[c]);
        end
        // latch at the next edge
        if (dv == DIV - 1 && sl == 8)
          for (int c = 0; c < NC; c++) begin
            exp_hold[c] = tx_data_i[c];
            if (!exp_inact[c]) exp_rx[c] = rxpat(fr, c);
          end
        // stimulus for the coming edge
        for (int c = 0; c < NC; c++)
          dr_i[c] = (sl >= 1 && sl <= 8) ? rxpat(fr, c)[8 - sl] : 1'b1;
        if (sl == 9 && dv == 0) begin
          for (int c = 0; c < NC; c++) tx_data_i[c] = txpat(fr + 2, c);
          if (fr == 3) en_i[1] = 1'b0;
          if (fr == 5) en_i[1] = 1'b1;
          if (fr == 6) en_i[0] = 1'b0;
          if (fr == 7) en_i[0] = 1'b1;
        end
        exp_inact = ~en_i;
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(10 * 60000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule